// File: doc/BRIEF.md
# PIO Timing Count Calculator

This block turns the timing needs of a disk drive's programmed-I/O transfers into clock counts that a drive interface timing register can hold. It takes the required address setup time, strobe active time and full cycle time in nanoseconds, together with the bus clock period in nanoseconds. Each time is divided by the period and rounded up. The block then applies the controller's lower and upper count limits and corrects the recovery count for later chip revisions. For a drive that shares a channel with its partner, it merges the result with that partner's counts.

A single start pulse latches all inputs. One shared bit-serial restoring divider then runs four divisions in turn: cycle, setup, active and recovery. When the final counts are ready, a one-cycle done pulse marks them. The results are the packed active/recovery byte and the 2-bit setup code, as the timing register holds them. The drive's own unmerged counts also come out, so that the surrounding logic can keep them and later feed them back as partner counts.

Top module: `pio_count_calc`

## Requirements
- R1: After reset, busy and done are low and every result output is zero. A start seen while busy is low latches all inputs, and busy is high from the next cycle. A start seen while busy is high is ignored and does not change the result.
- R2: Done is high for exactly one cycle, and busy is low in that cycle. The result outputs change only in a cycle where done is high and hold their value between done pulses.
- R3: The cycle, setup, active and recovery counts are each the time divided by the clock period, rounded up. A period input of 0 is treated as 1 ns. The own setup output carries the rounded-up setup count unchanged.
- R4: The recovery time is the cycle time minus the setup and active times, taken as 0 if that would be negative. The recovery count is the larger of its rounded-up value and (cycle count − setup count − active count), with that difference also taken as 0 when negative.
- R5: The active count and the recovery count are each raised to at least 2. The active minimum is applied before it is used in the R4 difference.
- R6: If the recovery count exceeds 17, the excess is added to the active count and recovery becomes 17. The active count is then capped at 16.
- R7: When the 2-bit chip revision is greater than 1, the recovery count is reduced by 1. Recovery is then capped at 16. The own active and own recovery outputs carry these values (active 2..16, recovery 1..16).
- R8: When the drive index is 2 or 3 and the partner-present input is high, each of the setup, active and recovery counts used for the packed byte and code is the larger of the own value and the partner's value. Otherwise the own values are used.
- R9: The setup code maps a setup count of 4 to 2'b00, 3 to 2'b10, 1 or 2 to 2'b01, and any other value (0 or 5 and up) to 2'b11.
- R10: The packed byte holds the low 4 bits of the active count in bits 7:4 and the low 4 bits of the recovery count in bits 3:0, so a count of 16 becomes a zero nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Latch inputs and begin a calculation |
| clk_period_ns | input | CLK_W | Bus clock period in ns (0 treated as 1) |
| setup_ns | input | TIME_W | Required address setup time in ns |
| active_ns | input | TIME_W | Required strobe active time in ns |
| cycle_ns | input | TIME_W | Required full cycle time in ns |
| chip_rev | input | 2 | Controller revision |
| drive_idx | input | 2 | Drive number 0..3 (2 and 3 share a channel) |
| mate_present | input | 1 | Partner drive on the shared channel exists |
| mate_setup | input | TIME_W | Partner's setup count |
| mate_active | input | 5 | Partner's active count |
| mate_recovery | input | 5 | Partner's recovery count |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle pulse, results valid |
| drw_byte | output | 8 | Packed active/recovery nibbles |
| setup_code | output | 2 | Encoded setup count |
| own_setup | output | TIME_W | Unmerged setup count |
| own_active | output | 5 | Unmerged active count after limits |
| own_recovery | output | 5 | Unmerged recovery count after limits and revision |

## Verification
A new start pulse can arrive while a calculation is still running. In that same window the partner merge and the limit stages depend on inputs the outside world is free to change. The bench provokes this by pulsing start with a completely different input set a few cycles into a run. It judges the result by comparing the next done result against a model of the first input set only. It also changes every input after done and confirms that the result outputs hold. The main sweep crosses clock periods, including 0, with setup, active and cycle times that exercise rounding, negative differences and the spill above 17. It also varies the revision, the drive index and the partner values. Each field is compared with an arithmetic model computed in the bench.

// File: rtl/pio_count_pkg.sv
package pio_count_pkg;

    // Fixed by the timing register format
    localparam int unsigned CNT_W      = 5;
    localparam int unsigned ACT_MIN    = 2;
    localparam int unsigned REC_MIN    = 2;
    localparam int unsigned REC_SPILL  = 17;
    localparam int unsigned CNT_CAP    = 16;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_WAIT,
        ST_FIN
    } calc_state_t;

    typedef enum logic [1:0] {
        OP_CYC = 2'd0,
        OP_SET = 2'd1,
        OP_ACT = 2'd2,
        OP_REC = 2'd3
    } div_op_t;

    typedef struct packed {
        logic [7:0] drw;
        logic [1:0] code;
    } timing_word_t;

    function automatic int unsigned sat_sub(input int unsigned a, input int unsigned b);
        return (a > b) ? (a - b) : 0;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [1:0] setup_code_of(input int unsigned n);
        logic [1:0] c;
        case (n)
            4:       c = 2'b00;
            3:       c = 2'b10;
            1, 2:    c = 2'b01;
            default: c = 2'b11;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/ptc_divider.sv
module ptc_divider #(
    parameter int unsigned DVD_W = 10,
    parameter int unsigned DVS_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DVD_W-1:0] dividend,
    input  logic [DVS_W-1:0] divisor,
    output logic [DVD_W-1:0] quo_ceil,
    output logic             done
);
    localparam int unsigned STEP_W = $clog2(DVD_W + 1);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(DVD_W - 1);

    logic [DVD_W-1:0]  dq;
    logic [DVS_W:0]    rem;
    logic [DVS_W-1:0]  dvs;
    logic [STEP_W-1:0] step;
    logic              run;

    logic [DVS_W:0] shifted;
    logic [DVS_W:0] next_rem;
    logic           take;

    always_comb begin
        shifted  = {rem[DVS_W-1:0], dq[DVD_W-1]};
        take     = (shifted >= {1'b0, dvs});
        next_rem = take ? (shifted - {1'b0, dvs}) : shifted;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dq   <= '0;
            rem  <= '0;
            dvs  <= '0;
            step <= '0;
            run  <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                dq   <= dividend;
                rem  <= '0;
                dvs  <= divisor;
                step <= '0;
                run  <= 1'b1;
            end else if (run) begin
                dq   <= {dq[DVD_W-2:0], take};
                rem  <= next_rem;
                step <= step + 1'b1;
                if (step == LAST_STEP) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // A nonzero remainder bumps the quotient up by one
    assign quo_ceil = dq + {{(DVD_W-1){1'b0}}, |rem};

endmodule

// File: rtl/ptc_limits.sv
module ptc_limits
    import pio_count_pkg::*;
#(
    parameter int unsigned TIME_W = 10
) (
    input  logic [TIME_W-1:0] q_cyc,
    input  logic [TIME_W-1:0] q_set,
    input  logic [TIME_W-1:0] q_act,
    input  logic [TIME_W-1:0] q_rec,
    input  logic [1:0]        rev,
    output logic [CNT_W-1:0]  act_out,
    output logic [CNT_W-1:0]  rec_out
);
    int unsigned act_i;
    int unsigned rec_i;

    always_comb begin
        act_i = max_u(32'(q_act), ACT_MIN);
        rec_i = sat_sub(32'(q_cyc), 32'(q_set) + act_i);
        rec_i = max_u(rec_i, 32'(q_rec));
        rec_i = max_u(rec_i, REC_MIN);
        if (rec_i > REC_SPILL) begin
            act_i = act_i + (rec_i - REC_SPILL);
            rec_i = REC_SPILL;
        end
        if (act_i > CNT_CAP) act_i = CNT_CAP;
        if (rev > 2'd1) rec_i = rec_i - 1;
        if (rec_i > CNT_CAP) rec_i = CNT_CAP;
        act_out = CNT_W'(act_i);
        rec_out = CNT_W'(rec_i);
    end

endmodule

// File: rtl/ptc_merge_pack.sv
module ptc_merge_pack
    import pio_count_pkg::*;
#(
    parameter int unsigned TIME_W = 10
) (
    input  logic               shared,
    input  logic [TIME_W-1:0]  own_set,
    input  logic [CNT_W-1:0]   own_act,
    input  logic [CNT_W-1:0]   own_rec,
    input  logic [TIME_W-1:0]  mate_set,
    input  logic [CNT_W-1:0]   mate_act,
    input  logic [CNT_W-1:0]   mate_rec,
    output timing_word_t       word
);
    logic [TIME_W-1:0] set_m;
    logic [CNT_W-1:0]  act_m;
    logic [CNT_W-1:0]  rec_m;

    always_comb begin
        set_m = own_set;
        act_m = own_act;
        rec_m = own_rec;
        if (shared) begin
            if (mate_set > set_m) set_m = mate_set;
            if (mate_act > act_m) act_m = mate_act;
            if (mate_rec > rec_m) rec_m = mate_rec;
        end
        word.code = setup_code_of(32'(set_m));
        word.drw  = {act_m[3:0], rec_m[3:0]};
    end

endmodule

// File: rtl/pio_count_calc.sv
module pio_count_calc
    import pio_count_pkg::*;
#(
    parameter int unsigned TIME_W = 10,
    parameter int unsigned CLK_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CLK_W-1:0]  clk_period_ns,
    input  logic [TIME_W-1:0] setup_ns,
    input  logic [TIME_W-1:0] active_ns,
    input  logic [TIME_W-1:0] cycle_ns,
    input  logic [1:0]        chip_rev,
    input  logic [1:0]        drive_idx,
    input  logic              mate_present,
    input  logic [TIME_W-1:0] mate_setup,
    input  logic [4:0]        mate_active,
    input  logic [4:0]        mate_recovery,
    output logic              busy,
    output logic              done,
    output logic [7:0]        drw_byte,
    output logic [1:0]        setup_code,
    output logic [TIME_W-1:0] own_setup,
    output logic [4:0]        own_active,
    output logic [4:0]        own_recovery
);
    calc_state_t       state;
    div_op_t           op_sel;

    logic [CLK_W-1:0]  per_r;
    logic [TIME_W-1:0] set_r, act_r, cyc_r, mset_r;
    logic [CNT_W-1:0]  mact_r, mrec_r;
    logic [1:0]        rev_r;
    logic              shared_r;

    logic [TIME_W-1:0] q_r [4];

    logic [TIME_W-1:0] rec_ns;
    logic [TIME_W-1:0] dvd;
    logic [TIME_W-1:0] div_q;
    logic              div_done;
    logic              div_start;

    logic [CNT_W-1:0]  lim_act, lim_rec;
    timing_word_t      word;

    // Recovery time saturates at zero when setup plus active exceed the cycle
    assign rec_ns = TIME_W'(sat_sub(32'(cyc_r), 32'(set_r) + 32'(act_r)));

    always_comb begin
        case (op_sel)
            OP_CYC:  dvd = cyc_r;
            OP_SET:  dvd = set_r;
            OP_ACT:  dvd = act_r;
            default: dvd = rec_ns;
        endcase
    end

    assign div_start = (state == ST_LAUNCH);
    assign busy      = (state != ST_IDLE);

    ptc_divider #(
        .DVD_W (TIME_W),
        .DVS_W (CLK_W)
    ) div_i (
        .clk      (clk),
        .rst      (rst),
        .start    (div_start),
        .dividend (dvd),
        .divisor  (per_r),
        .quo_ceil (div_q),
        .done     (div_done)
    );

    ptc_limits #(
        .TIME_W (TIME_W)
    ) lim_i (
        .q_cyc   (q_r[OP_CYC]),
        .q_set   (q_r[OP_SET]),
        .q_act   (q_r[OP_ACT]),
        .q_rec   (q_r[OP_REC]),
        .rev     (rev_r),
        .act_out (lim_act),
        .rec_out (lim_rec)
    );

    ptc_merge_pack #(
        .TIME_W (TIME_W)
    ) mrg_i (
        .shared   (shared_r),
        .own_set  (q_r[OP_SET]),
        .own_act  (lim_act),
        .own_rec  (lim_rec),
        .mate_set (mset_r),
        .mate_act (mact_r),
        .mate_rec (mrec_r),
        .word     (word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            op_sel       <= OP_CYC;
            per_r        <= '0;
            set_r        <= '0;
            act_r        <= '0;
            cyc_r        <= '0;
            mset_r       <= '0;
            mact_r       <= '0;
            mrec_r       <= '0;
            rev_r        <= '0;
            shared_r     <= 1'b0;
            for (int i = 0; i < 4; i++) q_r[i] <= '0;
            done         <= 1'b0;
            drw_byte     <= '0;
            setup_code   <= '0;
            own_setup    <= '0;
            own_active   <= '0;
            own_recovery <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        per_r    <= (clk_period_ns == '0) ? CLK_W'(1) : clk_period_ns;
                        set_r    <= setup_ns;
                        act_r    <= active_ns;
                        cyc_r    <= cycle_ns;
                        mset_r   <= mate_setup;
                        mact_r   <= mate_active;
                        mrec_r   <= mate_recovery;
                        rev_r    <= chip_rev;
                        shared_r <= drive_idx[1] & mate_present;
                        op_sel   <= OP_CYC;
                        state    <= ST_LAUNCH;
                    end
                end
                ST_LAUNCH: state <= ST_WAIT;
                ST_WAIT: begin
                    if (div_done) begin
                        q_r[op_sel] <= div_q;
                        if (op_sel == OP_REC) begin
                            state <= ST_FIN;
                        end else begin
                            op_sel <= div_op_t'(op_sel + 2'd1);
                            state  <= ST_LAUNCH;
                        end
                    end
                end
                default: begin
                    drw_byte     <= word.drw;
                    setup_code   <= word.code;
                    own_setup    <= q_r[OP_SET];
                    own_active   <= lim_act;
                    own_recovery <= lim_rec;
                    done         <= 1'b1;
                    state        <= ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/pio_count_calc_chk.sv
module pio_count_calc_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic [7:0] drw_byte,
    input logic [1:0] setup_code,
    input logic [4:0] own_active,
    input logic [4:0] own_recovery
);
    // R1
    start_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R1
    busy_exit_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R2
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(drw_byte) && $stable(setup_code)));

    // R5
    act_range_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (own_active >= 5'd2 && own_active <= 5'd16));

    // R7
    rec_range_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (own_recovery >= 5'd1 && own_recovery <= 5'd16));

endmodule

bind pio_count_calc pio_count_calc_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .busy         (busy),
    .done         (done),
    .drw_byte     (drw_byte),
    .setup_code   (setup_code),
    .own_active   (own_active),
    .own_recovery (own_recovery)
);

// File: tb/pio_count_calc_tb_top.sv
module pio_count_calc_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TW = 10;
    localparam int CW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [CW-1:0] clk_period_ns = '0;
    logic [TW-1:0] setup_ns = '0, active_ns = '0, cycle_ns = '0;
    logic [1:0]    chip_rev = '0, drive_idx = '0;
    logic          mate_present = 1'b0;
    logic [TW-1:0] mate_setup = '0;
    logic [4:0]    mate_active = '0, mate_recovery = '0;
    logic          busy, done;
    logic [7:0]    drw_byte;
    logic [1:0]    setup_code;
    logic [TW-1:0] own_setup;
    logic [4:0]    own_active, own_recovery;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pio_count_calc #(.TIME_W(TW), .CLK_W(CW)) dut_i (
        .clk(clk), .rst(rst), .start(start), .clk_period_ns(clk_period_ns),
        .setup_ns(setup_ns), .active_ns(active_ns), .cycle_ns(cycle_ns),
        .chip_rev(chip_rev), .drive_idx(drive_idx), .mate_present(mate_present),
        .mate_setup(mate_setup), .mate_active(mate_active), .mate_recovery(mate_recovery),
        .busy(busy), .done(done), .drw_byte(drw_byte), .setup_code(setup_code),
        .own_setup(own_setup), .own_active(own_active), .own_recovery(own_recovery)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Arithmetic model of the requirements
    function automatic void model(input int per, input int s, input int a, input int c,
                                  input int rev, input int idx, input int mp,
                                  input int ms, input int ma, input int mr,
                                  output int os, output int oa, output int orc,
                                  output int ob, output int oc);
        int d, rn, qc, qs, qa, qr, act, rec, rec2, fs, fa, fr;
        d  = (per == 0) ? 1 : per;
        rn = c - s - a;
        if (rn < 0) rn = 0;
        qc = (c + d - 1) / d;
        qs = (s + d - 1) / d;
        qa = (a + d - 1) / d;
        qr = (rn + d - 1) / d;
        act = (qa < 2) ? 2 : qa;
        rec2 = qc - qs - act;
        if (rec2 < 0) rec2 = 0;
        rec = (qr > rec2) ? qr : rec2;
        if (rec < 2) rec = 2;
        if (rec > 17) begin
            act = act + rec - 17;
            rec = 17;
        end
        if (act > 16) act = 16;
        if (rev > 1) rec = rec - 1;
        if (rec > 16) rec = 16;
        os = qs; oa = act; orc = rec;
        fs = qs; fa = act; fr = rec;
        if (idx >= 2 && mp != 0) begin
            if (ms > fs) fs = ms;
            if (ma > fa) fa = ma;
            if (mr > fr) fr = mr;
        end
        case (fs)
            4:       oc = 0;
            3:       oc = 2;
            1, 2:    oc = 1;
            default: oc = 3;
        endcase
        ob = ((fa & 15) << 4) | (fr & 15);
    endfunction

    task automatic drive_in(input int per, input int s, input int a, input int c,
                            input int rev, input int idx, input int mp,
                            input int ms, input int ma, input int mr);
        clk_period_ns = CW'(per);
        setup_ns      = TW'(s);
        active_ns     = TW'(a);
        cycle_ns      = TW'(c);
        chip_rev      = 2'(rev);
        drive_idx     = 2'(idx);
        mate_present  = (mp != 0);
        mate_setup    = TW'(ms);
        mate_active   = 5'(ma);
        mate_recovery = 5'(mr);
    endtask

    task automatic wait_done();
        while (done !== 1'b1) @(negedge clk);
    endtask

    task automatic run_and_check(input int per, input int s, input int a, input int c,
                                 input int rev, input int idx, input int mp,
                                 input int ms, input int ma, input int mr);
        int es, ea, er, eb, ec;
        model(per, s, a, c, rev, idx, mp, ms, ma, mr, es, ea, er, eb, ec);
        @(negedge clk);
        drive_in(per, s, a, c, rev, idx, mp, ms, ma, mr);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        chk("R3 own_setup", int'(own_setup), es);
        chk("R5 R6 own_active", int'(own_active), ea);
        chk("R4 R7 own_recovery", int'(own_recovery), er);
        chk("R8 R10 drw_byte", int'(drw_byte), eb);
        chk("R8 R9 setup_code", int'(setup_code), ec);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int es, ea, er, eb, ec, hold_b, hold_c;
        int per_l[4]  = '{0, 7, 20, 33};
        int set_l[3]  = '{0, 25, 70};
        int act_l[4]  = '{0, 90, 165, 290};
        int cyc_l[6]  = '{0, 120, 240, 383, 600, 1023};
        int rev_l[2]  = '{1, 3};
        int n;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset busy", int'(busy), 0);
        chk("R1 reset done", int'(done), 0);
        chk("R1 reset drw_byte", int'(drw_byte), 0);
        chk("R1 reset setup_code", int'(setup_code), 0);

        // R1 busy rises after accepted start
        drive_in(10, 31, 80, 600, 1, 0, 0, 0, 0, 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R1 busy after start", int'(busy), 1);
        wait_done();
        // R2 busy low in the done cycle; R3 31ns at 10ns rounds to 4
        chk("R2 busy low with done", int'(busy), 0);
        chk("R3 setup rounded up", int'(own_setup), 4);
        chk("R9 setup 4 gives 00", int'(setup_code), 0);
        // R6 spill: act 8+32 capped 16, rec 17 capped 16, byte 0x00
        chk("R6 active capped", int'(own_active), 16);
        chk("R10 sixteen packs to zero", int'(drw_byte), 0);
        @(negedge clk);
        chk("R2 done one cycle", int'(done), 0);

        // R2 outputs hold while inputs change with no start
        hold_b = int'(drw_byte);
        hold_c = int'(setup_code);
        drive_in(5, 3, 3, 20, 3, 3, 1, 9, 9, 9);
        repeat (6) @(negedge clk);
        chk("R2 byte held", int'(drw_byte), hold_b);
        chk("R2 code held", int'(setup_code), hold_c);
        chk("R2 no spurious done", int'(done), 0);

        // R1 start during busy ignored
        model(20, 70, 165, 383, 1, 0, 0, 0, 0, 0, es, ea, er, eb, ec);
        @(negedge clk);
        drive_in(20, 70, 165, 383, 1, 0, 0, 0, 0, 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        drive_in(7, 0, 0, 1023, 3, 2, 1, 12, 16, 16);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        chk("R1 ignored start byte", int'(drw_byte), eb);
        chk("R1 ignored start code", int'(setup_code), ec);
        chk("R1 ignored start recovery", int'(own_recovery), er);

        // R3 zero period treated as 1 ns
        run_and_check(0, 3, 5, 40, 1, 0, 0, 0, 0, 0);
        // R8 merge on shared channel vs not on primary
        run_and_check(30, 70, 90, 240, 1, 2, 1, 5, 12, 3);
        run_and_check(30, 70, 90, 240, 1, 1, 1, 5, 12, 3);
        run_and_check(30, 70, 90, 240, 1, 3, 0, 5, 12, 3);

        // Sweep
        n = 0;
        foreach (per_l[ip])
            foreach (set_l[is])
                foreach (act_l[ia])
                    foreach (cyc_l[ic])
                        foreach (rev_l[ir]) begin
                            run_and_check(per_l[ip], set_l[is], act_l[ia], cyc_l[ic],
                                          rev_l[ir], n % 4, ((n % 3) != 0) ? 1 : 0,
                                          n % 7, 2 + (n % 15), 1 + (n % 16));
                            n++;
                        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule